// File: doc/BRIEF.md
# Three-Phase Commutation and Brake Controller

This block turns three Hall sensor bits into gate enables for a three-phase bridge. The upper arm of each phase is switched plainly on or off. The lower arm carries the PWM carrier. The block drives the motor forward or in reverse, and it can force the lower arm to full duty. It also handles standby and three braking behaviours: a plug brake, a plug brake that hands over to regenerative braking, and regenerative braking alone. An invalid Hall code shuts the bridge down. After each rising edge of the carrier, a blanking window hides the current-limit comparator for a length chosen by one bit.

A speed flag from outside reports when the rotor has slowed to one eighth of nominal. Braking uses this flag to end the plug phase, and the block reports it back through a brake-done output. All outputs are registered, so the bridge never sees a combinational glitch from the Hall inputs.

Top module: `bldc_commutator`

## Requirements
- R1: In forward drive (motorOn=1, reverse=0) the Hall code {hall[2],hall[1],hall[0]} (bit 0 = phase U sensor) selects one upper and one lower arm. Arm vectors use bit 0 = U, bit 1 = V, bit 2 = W. The pairs are: 001 gives U upper and V lower; 011 gives U upper and W lower; 010 gives V upper and W lower; 110 gives V upper and U lower; 100 gives W upper and U lower; 101 gives W upper and V lower.
- R2: With reverse=1 the arms chosen by R1 swap roles: the phase named as upper is driven on its lower arm, and the phase named as lower is driven on its upper arm.
- R3: The chosen lower arm is on only while the sampled pwmCarrier is 1 and no current-limit trip is active. The chosen upper arm stays on whatever the carrier does.
- R4: With fullDuty=1 the chosen lower arm stays on continuously. The carrier and curLimit have no effect on it.
- R5: A rising edge of pwmCarrier opens a blanking window. It covers the clock edge that sees the rise plus the following N edges. N is SHORT_MASK (24) when longMask=0 at the rise and LONG_MASK (48) when longMask=1. curLimit sampled inside the window is ignored.
- R6: A curLimit sample of 1 outside the window turns the lower arm off at that edge. The arm stays off until the next rising edge of the carrier.
- R7: Hall codes 000 and 111 are invalid and force all six arm enables to 0.
- R8: Standby (motorOn=0, brakeSel=00) turns all arms off and holds brakeDone at 1.
- R9: brakeSel=01 with motorOn=0 plug-brakes: it commutates as R1 with the direction opposite to reverse, with PWM as in R3 to R6, until slowFlag is seen. After that all arms are off and brakeDone=1.
- R10: brakeSel=10 with motorOn=0 plug-brakes as in R9 until slowFlag is seen. After that it applies regenerative braking: all three lower arms on continuously and all upper arms off.
- R11: brakeSel=11 with motorOn=0 applies regenerative braking at once. brakeDone goes to 1 from the first edge at which slowFlag is sampled high.
- R12: motorOn=1 selects normal drive whatever brakeSel holds and keeps brakeDone at 0. Once slowFlag has been seen during braking, it is remembered until motorOn=1 or brakeSel=00.
- R13: Every output changes at the first clock edge after the input that causes it. During reset all arm enables are 0 and brakeDone is 1.
- R14: An upper and a lower arm of the same phase are never on together. At most one upper arm is on at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rstN | input | 1 | Active-low synchronous reset |
| hall | input | 3 | Hall sensor states, bit 0 = U |
| pwmCarrier | input | 1 | PWM carrier, 1 = on phase |
| curLimit | input | 1 | Current-limit comparator, 1 = over limit |
| longMask | input | 1 | Blanking length select |
| fullDuty | input | 1 | Force lower arm to 100% duty |
| reverse | input | 1 | Reverse commutation direction |
| motorOn | input | 1 | Normal drive enable |
| brakeSel | input | 2 | Brake mode when motorOn=0 |
| slowFlag | input | 1 | Rotor below one eighth of nominal speed |
| upperEn | output | 3 | Upper-arm enables, bit 0 = U |
| lowerEn | output | 3 | Lower-arm enables, bit 0 = U |
| brakeDone | output | 1 | Braking-complete flag |

## Verification
Every arm enable and brakeDone is due exactly one clock edge after the inputs that set it. The bench drives inputs on the falling edge, computes the expected outputs for the coming rising edge, and compares them on the next falling edge. The blanking window is the one result that spans many cycles. The bench's model counts edges from the carrier rise, so a curLimit held high must leave the lower arm on for N+1 samples and drop it on the sample after those. The remembered slow flag and the trip are likewise carried as model state from edge to edge, never read back from the design.

// File: rtl/bldc_pkg.sv
package bldc_pkg;

  localparam logic [1:0] BRK_NONE  = 2'b00;
  localparam logic [1:0] BRK_PLUG  = 2'b01;
  localparam logic [1:0] BRK_STAGE = 2'b10;
  localparam logic [1:0] BRK_REGEN = 2'b11;

  typedef enum logic [2:0] {
    MODE_STANDBY,
    MODE_DRIVE,
    MODE_PLUG,
    MODE_REGEN,
    MODE_COAST
  } bridge_mode_t;

  // strobes from control to datapath
  typedef struct packed {
    logic commute;  // drive the Hall-selected pair
    logic swapDir;  // exchange upper/lower roles
    logic pwmOn;    // lower arm gate for this cycle
    logic regen;    // all lower arms on, uppers off
  } arm_strobe_t;

endpackage

// File: rtl/commut_ctrl.sv
module commut_ctrl
  import bldc_pkg::*;
#(
  parameter int SHORT_MASK = 24,
  parameter int LONG_MASK  = 48
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        pwmCarrier,
  input  logic        curLimit,
  input  logic        longMask,
  input  logic        fullDuty,
  input  logic        reverse,
  input  logic        motorOn,
  input  logic [1:0]  brakeSel,
  input  logic        slowFlag,
  output arm_strobe_t strobe,
  output logic        brakeDone
);

  localparam int CW = $clog2(LONG_MASK + 1);
  localparam logic [CW-1:0] SHORT_LOAD = CW'(SHORT_MASK);
  localparam logic [CW-1:0] LONG_LOAD  = CW'(LONG_MASK);

  logic          pwmPrev;
  logic [CW-1:0] maskCnt;
  logic          tripQ;
  logic          reachedQ;

  logic          pwmRise;
  logic          blankNow;
  logic          tripEff;
  logic          reachedNow;
  bridge_mode_t  mode;

  // carrier edge and blanking window
  always_comb begin
    pwmRise  = pwmCarrier & ~pwmPrev;
    blankNow = pwmRise | (maskCnt != '0);
    tripEff  = (tripQ & ~pwmRise) | (curLimit & ~blankNow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pwmPrev <= 1'b0;
      maskCnt <= '0;
      tripQ   <= 1'b0;
    end else begin
      pwmPrev <= pwmCarrier;
      tripQ   <= tripEff;
      if (pwmRise)
        maskCnt <= longMask ? LONG_LOAD : SHORT_LOAD;
      else if (maskCnt != '0)
        maskCnt <= maskCnt - 1'b1;
    end
  end

  // mode selection
  always_comb begin
    reachedNow = reachedQ | slowFlag;
    if (motorOn)
      mode = MODE_DRIVE;
    else begin
      unique case (brakeSel)
        BRK_NONE:  mode = MODE_STANDBY;
        BRK_PLUG:  mode = reachedNow ? MODE_COAST : MODE_PLUG;
        BRK_STAGE: mode = reachedNow ? MODE_REGEN : MODE_PLUG;
        default:   mode = MODE_REGEN;
      endcase
    end
  end

  always_comb begin
    strobe.commute = (mode == MODE_DRIVE) | (mode == MODE_PLUG);
    strobe.swapDir = reverse ^ (mode == MODE_PLUG);
    strobe.pwmOn   = fullDuty | (pwmCarrier & ~tripEff);
    strobe.regen   = (mode == MODE_REGEN);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reachedQ  <= 1'b0;
      brakeDone <= 1'b1;
    end else if (motorOn) begin
      reachedQ  <= 1'b0;
      brakeDone <= 1'b0;
    end else if (brakeSel == BRK_NONE) begin
      reachedQ  <= 1'b0;
      brakeDone <= 1'b1;
    end else begin
      reachedQ  <= reachedNow;
      brakeDone <= reachedNow;
    end
  end

  // R8: standby raises the flag on the next edge
  a_r8_standby_done: assert property (@(posedge clk) disable iff (!rstN)
    (!motorOn && brakeSel == BRK_NONE) |=> brakeDone);

  // R12: drive clears the flag on the next edge
  a_r12_drive_not_done: assert property (@(posedge clk) disable iff (!rstN)
    motorOn |=> !brakeDone);

  // R5: inside the window a live carrier is never gated off
  a_r5_blank_keeps_pwm: assert property (@(posedge clk) disable iff (!rstN)
    (maskCnt != '0 && pwmCarrier && !tripQ) |-> strobe.pwmOn);

  // R6: a held trip keeps the lower arm off until the carrier rises
  a_r6_trip_holds: assert property (@(posedge clk) disable iff (!rstN)
    (tripQ && !fullDuty && !(pwmCarrier && !pwmPrev)) |-> !strobe.pwmOn);

  // R11: regenerative mode reports the flag once the speed flag is seen
  a_r11_regen_done: assert property (@(posedge clk) disable iff (!rstN)
    (!motorOn && brakeSel == BRK_REGEN && slowFlag) |=> brakeDone);

endmodule

// File: rtl/commut_dp.sv
module commut_dp
  import bldc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [2:0]  hall,
  input  arm_strobe_t strobe,
  output logic [2:0]  upperEn,
  output logic [2:0]  lowerEn
);

  localparam int PHASES = 3;

  // forward pair per Hall code: {lower, upper}, one-hot each
  function automatic logic [5:0] fwdPair(input logic [2:0] h);
    unique case (h)
      3'b001:  fwdPair = {3'b010, 3'b001};
      3'b011:  fwdPair = {3'b100, 3'b001};
      3'b010:  fwdPair = {3'b100, 3'b010};
      3'b110:  fwdPair = {3'b001, 3'b010};
      3'b100:  fwdPair = {3'b001, 3'b100};
      3'b101:  fwdPair = {3'b010, 3'b100};
      default: fwdPair = 6'b000000;
    endcase
  endfunction

  logic [5:0] pair;
  logic       hallFault;
  logic [2:0] upSel;
  logic [2:0] lowSel;

  always_comb begin
    pair      = fwdPair(hall);
    hallFault = (hall == 3'b000) | (hall == 3'b111);
    upSel     = strobe.swapDir ? pair[5:3] : pair[2:0];
    lowSel    = strobe.swapDir ? pair[2:0] : pair[5:3];
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      upperEn <= '0;
    else if (hallFault || !strobe.commute || strobe.regen)
      upperEn <= '0;
    else
      upperEn <= upSel;
  end

  for (genvar ph = 0; ph < PHASES; ph++) begin : g_lowArm
    always_ff @(posedge clk) begin
      if (!rstN)
        lowerEn[ph] <= 1'b0;
      else if (hallFault)
        lowerEn[ph] <= 1'b0;
      else if (strobe.regen)
        lowerEn[ph] <= 1'b1;
      else
        lowerEn[ph] <= strobe.commute & lowSel[ph] & strobe.pwmOn;
    end
  end

  // R7: invalid Hall code empties the bridge on the next edge
  a_r7_fault_off: assert property (@(posedge clk) disable iff (!rstN)
    (hall == 3'b000 || hall == 3'b111) |=> (upperEn == '0 && lowerEn == '0));

  // R14: no shoot-through
  a_r14_no_shoot: assert property (@(posedge clk) disable iff (!rstN)
    (upperEn & lowerEn) == '0);

  // R14: single upper arm
  a_r14_one_upper: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(upperEn));

endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
  import bldc_pkg::*;
#(
  parameter int SHORT_MASK = 24,
  parameter int LONG_MASK  = 48
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [2:0] hall,
  input  logic       pwmCarrier,
  input  logic       curLimit,
  input  logic       longMask,
  input  logic       fullDuty,
  input  logic       reverse,
  input  logic       motorOn,
  input  logic [1:0] brakeSel,
  input  logic       slowFlag,
  output logic [2:0] upperEn,
  output logic [2:0] lowerEn,
  output logic       brakeDone
);

  arm_strobe_t strobe;

  commut_ctrl #(
    .SHORT_MASK(SHORT_MASK),
    .LONG_MASK (LONG_MASK)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .pwmCarrier(pwmCarrier),
    .curLimit  (curLimit),
    .longMask  (longMask),
    .fullDuty  (fullDuty),
    .reverse   (reverse),
    .motorOn   (motorOn),
    .brakeSel  (brakeSel),
    .slowFlag  (slowFlag),
    .strobe    (strobe),
    .brakeDone (brakeDone)
  );

  commut_dp u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .hall   (hall),
    .strobe (strobe),
    .upperEn(upperEn),
    .lowerEn(lowerEn)
  );

endmodule

// File: tb/tb_bldc_commutator.sv
module tb_bldc_commutator;

  localparam int SHORT_N = 24;
  localparam int LONG_N  = 48;

  logic       clk = 1'b0;
  logic       rstN;
  logic [2:0] hall;
  logic       pwmCarrier, curLimit, longMask, fullDuty, reverse, motorOn, slowFlag;
  logic [1:0] brakeSel;
  logic [2:0] upperEn, lowerEn;
  logic       brakeDone;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  bldc_commutator #(.SHORT_MASK(SHORT_N), .LONG_MASK(LONG_N)) dut (
    .clk(clk), .rstN(rstN), .hall(hall), .pwmCarrier(pwmCarrier),
    .curLimit(curLimit), .longMask(longMask), .fullDuty(fullDuty),
    .reverse(reverse), .motorOn(motorOn), .brakeSel(brakeSel),
    .slowFlag(slowFlag), .upperEn(upperEn), .lowerEn(lowerEn),
    .brakeDone(brakeDone)
  );

  // reference state
  bit mPrevCar;
  int mSince;
  int mWin;
  bit mTrip;
  bit mReached;

  // R1 table: returns {lower, upper}
  function automatic logic [5:0] pairFor(input logic [2:0] h);
    case (h)
      3'b001: return {3'b010, 3'b001};
      3'b011: return {3'b100, 3'b001};
      3'b010: return {3'b100, 3'b010};
      3'b110: return {3'b001, 3'b010};
      3'b100: return {3'b001, 3'b100};
      3'b101: return {3'b010, 3'b100};
      default: return 6'b0;
    endcase
  endfunction

  task automatic modelReset();
    mPrevCar = 1'b0; mSince = 1000; mWin = SHORT_N; mTrip = 1'b0; mReached = 1'b0;
  endtask

  task automatic predict(output logic [2:0] eUp, output logic [2:0] eLow,
                         output logic eDone, output string tag);
    bit rise, blank, tripNow, pwmOk, reachedNow, plug, regen, drive, swp;
    logic [5:0] p;
    rise = pwmCarrier && !mPrevCar;
    if (rise) begin mSince = 0; mWin = longMask ? LONG_N : SHORT_N; end
    else if (mSince < 1000) mSince++;
    blank   = (mSince <= mWin);
    tripNow = (mTrip && !rise) || (curLimit && !blank);
    mTrip   = tripNow;
    mPrevCar = pwmCarrier;
    pwmOk = fullDuty || (pwmCarrier && !tripNow);
    plug = 0; regen = 0; drive = 0;
    reachedNow = mReached || slowFlag;
    if (motorOn) begin
      drive = 1; eDone = 0; mReached = 0;
      tag = fullDuty ? "R4" : (curLimit ? "R6" : (reverse ? "R2" : "R1"));
    end else if (brakeSel == 2'b00) begin
      eDone = 1; mReached = 0; tag = "R8";
    end else begin
      eDone = reachedNow; mReached = reachedNow;
      case (brakeSel)
        2'b01: begin plug = !reachedNow; tag = "R9"; end
        2'b10: begin plug = !reachedNow; regen = reachedNow; tag = "R10"; end
        default: begin regen = 1; tag = "R11"; end
      endcase
    end
    p = pairFor(hall);
    swp = reverse ^ plug;
    eUp = 3'b000; eLow = 3'b000;
    if (hall == 3'b000 || hall == 3'b111) tag = "R7";
    else if (regen) eLow = 3'b111;
    else if (drive || plug) begin
      eUp  = swp ? p[5:3] : p[2:0];
      eLow = (swp ? p[2:0] : p[5:3]) & {3{pwmOk}};
    end
  endtask

  task automatic check(input string tag, input logic [2:0] eUp,
                       input logic [2:0] eLow, input logic eDone);
    testsRun++;
    if (upperEn !== eUp || lowerEn !== eLow || brakeDone !== eDone) begin
      testsFailed++;
      $display("FAIL %s: up=%b low=%b done=%b expected up=%b low=%b done=%b",
               tag, upperEn, lowerEn, brakeDone, eUp, eLow, eDone);
    end
  endtask

  // inputs already applied at a falling edge; R13: one-edge latency
  task automatic step(input string forceTag = "");
    logic [2:0] eUp, eLow; logic eDone; string tag;
    predict(eUp, eLow, eDone, tag);
    if (forceTag != "") tag = forceTag;
    @(posedge clk);
    @(negedge clk);
    check(tag, eUp, eLow, eDone);
  endtask

  task automatic idle();
    hall = 3'b001; pwmCarrier = 0; curLimit = 0; longMask = 0; fullDuty = 0;
    reverse = 0; motorOn = 0; brakeSel = 2'b00; slowFlag = 0;
  endtask

  int seedVal;

  initial begin
    idle();
    rstN = 0;
    seedVal = $urandom(20240611);
    repeat (3) @(negedge clk);
    testsRun++;                              // R13 reset state
    if (upperEn !== 3'b0 || lowerEn !== 3'b0 || brakeDone !== 1'b1) begin
      testsFailed++;
      $display("FAIL R13: up=%b low=%b done=%b expected up=000 low=000 done=1",
               upperEn, lowerEn, brakeDone);
    end
    rstN = 1; modelReset();

    // R1/R2 all codes with full duty
    motorOn = 1; fullDuty = 1;
    for (int r = 0; r < 2; r++) begin
      reverse = r[0];
      for (int h = 0; h < 8; h++) begin hall = h[2:0]; step(); end
    end
    // R3 carrier low/high, upper steady
    fullDuty = 0; reverse = 0; hall = 3'b011;
    pwmCarrier = 0; step("R3"); step("R3");
    pwmCarrier = 1; step("R3"); pwmCarrier = 0; step("R3");
    // R5/R6 short window with limit held
    repeat (4) step("R3");
    curLimit = 1; longMask = 0; pwmCarrier = 1;
    for (int i = 0; i < SHORT_N + 6; i++) step("R5");
    pwmCarrier = 0; step("R6"); step("R6");
    // long window
    longMask = 1; pwmCarrier = 1;
    for (int i = 0; i < LONG_N + 6; i++) step("R5");
    // R4 limit ignored at full duty
    fullDuty = 1; step("R4"); step("R4");
    fullDuty = 0; step("R6");
    curLimit = 0; pwmCarrier = 0; step("R6");
    pwmCarrier = 1; step("R6");            // rise clears trip
    // R7 faults while driving
    hall = 3'b111; step("R7"); hall = 3'b000; step("R7");
    // R8 standby
    hall = 3'b110; motorOn = 0; brakeSel = 2'b00; step("R8"); step("R8");
    // R9 plug then coast
    brakeSel = 2'b01; fullDuty = 1; step("R9"); step("R9");
    slowFlag = 1; step("R9"); slowFlag = 0; step("R9"); step("R9");
    // R10 plug then regen
    brakeSel = 2'b00; step("R8");
    brakeSel = 2'b10; step("R10"); step("R10");
    slowFlag = 1; step("R10"); slowFlag = 0; step("R10");
    hall = 3'b111; step("R7"); hall = 3'b101;
    // R11 regen at once
    brakeSel = 2'b00; step("R8");
    brakeSel = 2'b11; step("R11"); step("R11");
    slowFlag = 1; step("R11"); slowFlag = 0; step("R11");
    // R12 motorOn overrides brake and clears memory
    motorOn = 1; step("R12"); step("R12");
    motorOn = 0; brakeSel = 2'b01; step("R12");

    // random phase
    idle(); motorOn = 1;
    begin
      int carLeft = 0;
      for (int cyc = 0; cyc < 6000; cyc++) begin
        if (carLeft == 0) begin
          pwmCarrier = ~pwmCarrier;
          carLeft = pwmCarrier ? 30 + int'($urandom_range(90)) : 10 + int'($urandom_range(50));
          longMask = $urandom_range(1);
        end
        carLeft--;
        if ($urandom_range(9) == 0) hall = $urandom_range(7);
        curLimit = ($urandom_range(15) == 0) ? ~curLimit : curLimit;
        slowFlag = ($urandom_range(40) == 0);
        if ($urandom_range(250) == 0) begin
          motorOn  = $urandom_range(1);
          brakeSel = $urandom_range(3);
          reverse  = $urandom_range(1);
          fullDuty = ($urandom_range(4) == 0);
        end
        step();
      end
    end

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule